// File: doc/BRIEF.md
# Operand Address Sequencer with Page-Cross Penalty

This block works out the 16-bit effective address of an operand for a small 8-bit processor. It covers the zero-page, zero-page-indexed, pre-indexed pointer, post-indexed pointer, zero-page pointer, absolute, absolute-indexed, pointer-jump and indexed-pointer-jump modes. Once a start pulse arrives, it drives one bus read per clock. Each read fetches operand bytes at the program counter, walks pointer bytes, or performs the dummy reads that real silicon makes. Read data is returned on `bus_data` in the same cycle as the address. When the sequence is over, the block pulses `done`. With that pulse it presents the effective address, the advanced program counter, the number of bus cycles it used and a flag that says whether an index carry across a page boundary cost an extra cycle.

A revision input picks between two silicon generations. They differ in where dummy reads land and in how the pointer jump forms the address of its high byte. The older part has a page-wrap defect in that step and the newer part fixes it. A second input marks instructions that always spend the indexing cycle, such as stores and read-modify-write operations.

Top module: `ea_gen`

## Requirements
- R1: After reset `busy`, `bus_rd` and `done` are 0, and `pc_out` is 0x0000.
- R2: A start pulse while idle begins a sequence. The first read is at `pc_in`. Two-byte operands are read low byte first from successive addresses. At `done`, `pc_out` equals `pc_in` plus the operand length: 2 for modes 5, 6, 7, 9 and 10, and 1 for all other modes. Mode codes 11 to 15 behave as mode 0.
- R3: Mode 0 (zero page) takes 1 cycle. Modes 1 and 2 (zero page indexed by X or Y) take 2 cycles and give {0x00, (byte + index) mod 256}. Their second cycle reads {0x00, byte} on the old revision (`later_rev`=0) and `pc_out` on the new one.
- R4: Mode 3 (pre-indexed pointer) takes 4 cycles. Its second cycle is the same dummy read as in R3. It then reads the pointer at {0x00, byte+X} and {0x00, byte+X+1}, both wrapping within page zero.
- R5: Mode 4 (post-indexed pointer) reads the pointer from page zero with wrap, then adds Y. If the high byte changes, a fourth cycle reads the unfixed address {base high, sum low} on the old revision or `pc_out` on the new one, and `page_cross` is 1.
- R6: With `force_extra`=1, an indexed mode (4, 6 or 7) that does not cross a page still spends one extra cycle, which reads the final address. `page_cross` is 0 in that case.
- R7: Mode 5 (absolute) takes 2 cycles. Modes 6 and 7 (absolute indexed by X or Y) take 2 cycles, or 3 when a page is crossed or when `force_extra` is set. Their extra read follows the same rule as in R5.
- R8: Mode 8 (zero-page pointer) takes 3 cycles and reads the target from {0x00, byte} and {0x00, byte+1}.
- R9: Mode 9 (pointer jump) on the old revision takes 4 cycles. The target high byte is read at {pointer high, pointer low + 1}, with no carry into the high byte.
- R10: Mode 9 on the new revision takes 5 cycles. The third cycle is a dummy read at `pc_out`, and the high byte comes from pointer + 1 with full carry.
- R11: Mode 10 (indexed pointer jump) takes 5 cycles on either revision. It reads the two pointer bytes, makes a dummy read at `pc_out`, then reads the target from pointer+X and pointer+X+1.
- R12: `done` is a one-cycle pulse in the cycle after the last read. At `done`, `cycles` equals the number of reads made, and `page_cross` is 1 only for modes 4, 6 and 7 when a carry crossed a page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (accepted when idle) |
| mode | input | 4 | Addressing mode code (0..10) |
| later_rev | input | 1 | 0: old revision, 1: new revision |
| force_extra | input | 1 | Instruction always spends the indexing cycle |
| pc_in | input | 16 | Address of the first operand byte |
| x_in | input | 8 | X index value |
| y_in | input | 8 | Y index value |
| bus_data | input | 8 | Read data for the current bus address |
| bus_addr | output | 16 | Address of the current read |
| bus_rd | output | 1 | A read is made this cycle |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| pc_out | output | 16 | Program counter after the operand bytes |
| cycles | output | 3 | Bus cycles used by the sequence |
| page_cross | output | 1 | An index carry crossed a page |

## Verification
The bound checker watches every cycle for several properties: the first read lands on `pc_in`, `done` follows directly on a read, the program counter advances by the operand length, zero-page modes never leave page zero, the page-cross flag appears only for the three indexed modes, and the cycle counts of the absolute-indexed and indexed-pointer-jump modes stay within their allowed values. Other behaviour can only be shown by the directed scenarios, which compare the full read trace against hand-worked values. That covers the exact dummy-read addresses on each revision, the unfixed guess address, the pointer-jump page-wrap defect against the carry fix, and the zero-page wrap of pointer bytes.

// File: rtl/ea_gen.sv
module ea_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic        later_rev,
  input  logic        force_extra,
  input  logic [15:0] pc_in,
  input  logic [7:0]  x_in,
  input  logic [7:0]  y_in,
  input  logic [7:0]  bus_data,
  output logic [15:0] bus_addr,
  output logic        bus_rd,
  output logic        busy,
  output logic        done,
  output logic [15:0] ea,
  output logic [15:0] pc_out,
  output logic [2:0]  cycles,
  output logic        page_cross
);
  localparam logic [3:0] M_ZP = 4'd0, M_ZPX = 4'd1, M_ZPY = 4'd2, M_IZX = 4'd3,
                         M_IZY = 4'd4, M_ABS = 4'd5, M_ABX = 4'd6, M_ABY = 4'd7,
                         M_ZPI = 4'd8, M_IND = 4'd9, M_AIX = 4'd10;

  typedef enum logic [2:0] {S_IDLE, S_OPL, S_OPH, S_DZP, S_DPC, S_PL, S_PH, S_FIX} st_t;

  st_t         st;
  logic [3:0]  md;
  logic        rev, ext;
  logic [7:0]  xr, yr, opl, oph, rlo;
  logic [15:0] pc, ptr, fixa, hold;
  logic [2:0]  cnt, cyc_q;
  logic        xcross, cross_q, done_q;
  logic [15:0] ea_q;

  wire         use_y  = (md == M_ZPY) || (md == M_ABY) || (md == M_IZY);
  wire [7:0]   idx    = use_y ? yr : xr;
  wire         full_c = (md == M_AIX) || (md == M_IND && rev);
  wire [15:0]  hi_ptr = full_c ? ptr + 16'd1 : {ptr[15:8], 8'(ptr[7:0] + 8'd1)};
  wire [15:0]  base   = (st == S_PH) ? {bus_data, rlo} : {bus_data, opl};
  wire [15:0]  sum    = base + {8'd0, idx};
  wire         carry  = sum[15:8] != base[15:8];
  wire [15:0]  pc_fix = (st == S_OPH) ? pc + 16'd1 : pc;
  wire [15:0]  guess  = {base[15:8], sum[7:0]};
  wire [15:0]  extra_a = carry ? (rev ? pc_fix : guess) : sum;

  always_comb begin
    case (st)
      S_OPL, S_OPH, S_DPC: bus_addr = pc;
      S_DZP:               bus_addr = rev ? pc : {8'h00, opl};
      S_PL:                bus_addr = ptr;
      S_PH:                bus_addr = hi_ptr;
      S_FIX:               bus_addr = fixa;
      default:             bus_addr = 16'h0000;
    endcase
  end

  assign bus_rd     = st != S_IDLE;
  assign busy       = st != S_IDLE;
  assign done       = done_q;
  assign ea         = ea_q;
  assign pc_out     = pc;
  assign cycles     = cyc_q;
  assign page_cross = cross_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      md      <= M_ZP;
      rev     <= 1'b0;
      ext     <= 1'b0;
      xr      <= 8'h00;
      yr      <= 8'h00;
      opl     <= 8'h00;
      oph     <= 8'h00;
      rlo     <= 8'h00;
      pc      <= 16'h0000;
      ptr     <= 16'h0000;
      fixa    <= 16'h0000;
      hold    <= 16'h0000;
      cnt     <= 3'd0;
      cyc_q   <= 3'd0;
      xcross  <= 1'b0;
      cross_q <= 1'b0;
      done_q  <= 1'b0;
      ea_q    <= 16'h0000;
    end else begin
      done_q <= 1'b0;
      if (st != S_IDLE) cnt <= cnt + 3'd1;
      case (st)
        S_IDLE: if (start) begin
          st  <= S_OPL;
          md  <= mode;
          rev <= later_rev;
          ext <= force_extra;
          xr  <= x_in;
          yr  <= y_in;
          pc  <= pc_in;
          cnt <= 3'd0;
        end
        S_OPL: begin
          opl <= bus_data;
          pc  <= pc + 16'd1;
          case (md)
            M_ZPX, M_ZPY, M_IZX: st <= S_DZP;
            M_IZY, M_ZPI: begin
              ptr <= {8'h00, bus_data};
              st  <= S_PL;
            end
            M_ABS, M_ABX, M_ABY, M_IND, M_AIX: st <= S_OPH;
            default: begin
              st      <= S_IDLE;
              done_q  <= 1'b1;
              cyc_q   <= cnt + 3'd1;
              ea_q    <= {8'h00, bus_data};
              cross_q <= 1'b0;
            end
          endcase
        end
        S_OPH: begin
          oph <= bus_data;
          pc  <= pc + 16'd1;
          case (md)
            M_ABX, M_ABY: begin
              if (carry || ext) begin
                st     <= S_FIX;
                fixa   <= extra_a;
                hold   <= sum;
                xcross <= carry;
              end else begin
                st      <= S_IDLE;
                done_q  <= 1'b1;
                cyc_q   <= cnt + 3'd1;
                ea_q    <= sum;
                cross_q <= 1'b0;
              end
            end
            M_IND: begin
              ptr <= {bus_data, opl};
              st  <= rev ? S_DPC : S_PL;
            end
            M_AIX: st <= S_DPC;
            default: begin
              st      <= S_IDLE;
              done_q  <= 1'b1;
              cyc_q   <= cnt + 3'd1;
              ea_q    <= {bus_data, opl};
              cross_q <= 1'b0;
            end
          endcase
        end
        S_DZP: begin
          if (md == M_IZX) begin
            ptr <= {8'h00, 8'(opl + xr)};
            st  <= S_PL;
          end else begin
            st      <= S_IDLE;
            done_q  <= 1'b1;
            cyc_q   <= cnt + 3'd1;
            ea_q    <= {8'h00, 8'(opl + idx)};
            cross_q <= 1'b0;
          end
        end
        S_DPC: begin
          if (md == M_AIX) ptr <= {oph, opl} + {8'd0, xr};
          st <= S_PL;
        end
        S_PL: begin
          rlo <= bus_data;
          st  <= S_PH;
        end
        S_PH: begin
          if (md == M_IZY && (carry || ext)) begin
            st     <= S_FIX;
            fixa   <= extra_a;
            hold   <= sum;
            xcross <= carry;
          end else begin
            st      <= S_IDLE;
            done_q  <= 1'b1;
            cyc_q   <= cnt + 3'd1;
            ea_q    <= (md == M_IZY) ? sum : {bus_data, rlo};
            cross_q <= 1'b0;
          end
        end
        S_FIX: begin
          st      <= S_IDLE;
          done_q  <= 1'b1;
          cyc_q   <= cnt + 3'd1;
          ea_q    <= hold;
          cross_q <= xcross;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ea_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [3:0]  mode,
  input logic [15:0] pc_in,
  input logic [15:0] bus_addr,
  input logic        bus_rd,
  input logic        busy,
  input logic        done,
  input logic [15:0] ea,
  input logic [15:0] pc_out,
  input logic [2:0]  cycles,
  input logic        page_cross
);
  logic [3:0]  md_c;
  logic [15:0] pc_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      md_c <= 4'd0;
      pc_c <= 16'h0000;
    end else if (start && !busy) begin
      md_c <= mode;
      pc_c <= pc_in;
    end
  end

  wire two_byte = md_c inside {4'd5, 4'd6, 4'd7, 4'd9, 4'd10};
  wire abs_idx  = md_c inside {4'd6, 4'd7};

  AST_FIRST_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start && !busy) |-> bus_rd && bus_addr == $past(pc_in)); // R2
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pc_out == pc_c + (two_byte ? 16'd2 : 16'd1)); // R2
  AST_ZP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    done && md_c inside {4'd0, 4'd1, 4'd2} |-> ea[15:8] == 8'h00); // R3
  AST_ABS_IDX_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    done && abs_idx |-> (page_cross ? cycles == 3'd3 : (cycles == 3'd2 || cycles == 3'd3))); // R7
  AST_AIX_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    done && md_c == 4'd10 |-> cycles == 3'd5); // R11
  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_rd) && !bus_rd); // R12
  AST_CROSS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    done && page_cross |-> md_c inside {4'd4, 4'd6, 4'd7}); // R12
endmodule

bind ea_gen ea_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc_in(pc_in),
  .bus_addr(bus_addr), .bus_rd(bus_rd), .busy(busy), .done(done), .ea(ea),
  .pc_out(pc_out), .cycles(cycles), .page_cross(page_cross)
);

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic        later_rev = 1'b0;
  logic        force_extra = 1'b0;
  logic [15:0] pc_in = 16'h0000;
  logic [7:0]  x_in = 8'h00;
  logic [7:0]  y_in = 8'h00;
  logic [7:0]  bus_data;
  logic [15:0] bus_addr, ea, pc_out;
  logic        bus_rd, busy, done, page_cross;
  logic [2:0]  cycles;

  int tests = 0;
  int fails = 0;

  logic [15:0] ov_a [8];
  logic [7:0]  ov_d [8];
  int          ov_n = 0;
  logic [15:0] tr [8];
  int          tn = 0;

  ea_gen u_ea_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .later_rev(later_rev),
    .force_extra(force_extra), .pc_in(pc_in), .x_in(x_in), .y_in(y_in),
    .bus_data(bus_data), .bus_addr(bus_addr), .bus_rd(bus_rd), .busy(busy),
    .done(done), .ea(ea), .pc_out(pc_out), .cycles(cycles), .page_cross(page_cross)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always_comb begin
    bus_data = 8'hEA;
    for (int i = 0; i < 8; i++)
      if (i < ov_n && ov_a[i] == bus_addr) bus_data = ov_d[i];
  end

  always @(negedge clk) begin
    if (bus_rd) begin
      if (tn < 8) tr[tn] = bus_addr;
      tn = tn + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic mem_clear();
    ov_n = 0;
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] d);
    ov_a[ov_n] = a;
    ov_d[ov_n] = d;
    ov_n++;
  endtask

  task automatic run(input logic [3:0] m, input logic [15:0] p, input logic [7:0] xv,
                     input logic [7:0] yv, input logic r, input logic e);
    int guard;
    @(negedge clk);
    mode = m; pc_in = p; x_in = xv; y_in = yv; later_rev = r; force_extra = e;
    tn = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 20) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic result(input string req, input logic [15:0] exp_ea, input int exp_cyc,
                        input logic exp_x, input logic [15:0] exp_pc,
                        input logic [15:0] ex [5], input int n);
    int bad;
    chk(req, "done", int'(done), 1);
    chk(req, "ea", int'(ea), int'(exp_ea));
    chk(req, "cycles", int'(cycles), exp_cyc);
    chk(req, "page_cross", int'(page_cross), int'(exp_x));
    chk(req, "pc_out", int'(pc_out), int'(exp_pc));
    chk(req, "read count", tn, n);
    bad = -1;
    for (int i = 0; i < n && i < tn; i++)
      if (bad < 0 && tr[i] != ex[i]) bad = i;
    if (bad >= 0) chk(req, $sformatf("read %0d address", bad), int'(tr[bad]), int'(ex[bad]));
    else chk(req, "read trace", 0, 0);
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "bus_rd", int'(bus_rd), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "pc_out", int'(pc_out), 0);
  endtask

  task automatic t_zero_page();
    mem_clear(); put(16'h0200, 8'h80);
    run(4'd0, 16'h0200, 8'h00, 8'h00, 1'b0, 1'b0);
    result("R2", 16'h0080, 1, 1'b0, 16'h0201, '{16'h0200, 0, 0, 0, 0}, 1);
    mem_clear(); put(16'h0300, 8'hF0);
    run(4'd1, 16'h0300, 8'h20, 8'h00, 1'b0, 1'b0);
    result("R3", 16'h0010, 2, 1'b0, 16'h0301, '{16'h0300, 16'h00F0, 0, 0, 0}, 2);
    run(4'd2, 16'h0300, 8'h00, 8'h05, 1'b1, 1'b0);
    result("R3", 16'h00F5, 2, 1'b0, 16'h0301, '{16'h0300, 16'h0301, 0, 0, 0}, 2);
    mem_clear(); put(16'h0210, 8'h33);
    run(4'd13, 16'h0210, 8'h00, 8'h00, 1'b0, 1'b0);
    result("R2", 16'h0033, 1, 1'b0, 16'h0211, '{16'h0210, 0, 0, 0, 0}, 1);
  endtask

  task automatic t_pre_indexed();
    mem_clear(); put(16'h0400, 8'hFE); put(16'h00FF, 8'h34); put(16'h0000, 8'h12);
    run(4'd3, 16'h0400, 8'h01, 8'h00, 1'b0, 1'b0);
    result("R4", 16'h1234, 4, 1'b0, 16'h0401,
           '{16'h0400, 16'h00FE, 16'h00FF, 16'h0000, 0}, 4);
    run(4'd3, 16'h0400, 8'h01, 8'h00, 1'b1, 1'b0);
    result("R4", 16'h1234, 4, 1'b0, 16'h0401,
           '{16'h0400, 16'h0401, 16'h00FF, 16'h0000, 0}, 4);
  endtask

  task automatic t_post_indexed();
    mem_clear(); put(16'h0500, 8'hFF); put(16'h00FF, 8'hF0); put(16'h0000, 8'h20);
    run(4'd4, 16'h0500, 8'h00, 8'h20, 1'b0, 1'b0);
    result("R5", 16'h2110, 4, 1'b1, 16'h0501,
           '{16'h0500, 16'h00FF, 16'h0000, 16'h2010, 0}, 4);
    run(4'd4, 16'h0500, 8'h00, 8'h20, 1'b1, 1'b0);
    result("R5", 16'h2110, 4, 1'b1, 16'h0501,
           '{16'h0500, 16'h00FF, 16'h0000, 16'h0501, 0}, 4);
    run(4'd4, 16'h0500, 8'h00, 8'h05, 1'b0, 1'b0);
    result("R5", 16'h20F5, 3, 1'b0, 16'h0501,
           '{16'h0500, 16'h00FF, 16'h0000, 0, 0}, 3);
    run(4'd4, 16'h0500, 8'h00, 8'h05, 1'b0, 1'b1);
    result("R6", 16'h20F5, 4, 1'b0, 16'h0501,
           '{16'h0500, 16'h00FF, 16'h0000, 16'h20F5, 0}, 4);
  endtask

  task automatic t_absolute();
    mem_clear(); put(16'h0600, 8'h78); put(16'h0601, 8'h56);
    run(4'd5, 16'h0600, 8'h00, 8'h00, 1'b0, 1'b0);
    result("R7", 16'h5678, 2, 1'b0, 16'h0602, '{16'h0600, 16'h0601, 0, 0, 0}, 2);
    mem_clear(); put(16'h0700, 8'hC0); put(16'h0701, 8'h12);
    run(4'd6, 16'h0700, 8'h50, 8'h00, 1'b0, 1'b0);
    result("R7", 16'h1310, 3, 1'b1, 16'h0702, '{16'h0700, 16'h0701, 16'h1210, 0, 0}, 3);
    run(4'd7, 16'h0700, 8'h00, 8'h50, 1'b1, 1'b0);
    result("R7", 16'h1310, 3, 1'b1, 16'h0702, '{16'h0700, 16'h0701, 16'h0702, 0, 0}, 3);
    run(4'd6, 16'h0700, 8'h10, 8'h00, 1'b0, 1'b1);
    result("R6", 16'h12D0, 3, 1'b0, 16'h0702, '{16'h0700, 16'h0701, 16'h12D0, 0, 0}, 3);
    run(4'd6, 16'h0700, 8'h10, 8'h00, 1'b1, 1'b0);
    result("R7", 16'h12D0, 2, 1'b0, 16'h0702, '{16'h0700, 16'h0701, 0, 0, 0}, 2);
  endtask

  task automatic t_zp_pointer();
    mem_clear(); put(16'h0800, 8'h40); put(16'h0040, 8'hCD); put(16'h0041, 8'hAB);
    run(4'd8, 16'h0800, 8'h00, 8'h00, 1'b0, 1'b0);
    result("R8", 16'hABCD, 3, 1'b0, 16'h0801, '{16'h0800, 16'h0040, 16'h0041, 0, 0}, 3);
  endtask

  task automatic t_jumps();
    mem_clear(); put(16'h0900, 8'hFF); put(16'h0901, 8'h30);
    put(16'h30FF, 8'h80); put(16'h3000, 8'h50); put(16'h3100, 8'h60);
    run(4'd9, 16'h0900, 8'h00, 8'h00, 1'b0, 1'b0);
    result("R9", 16'h5080, 4, 1'b0, 16'h0902,
           '{16'h0900, 16'h0901, 16'h30FF, 16'h3000, 0}, 4);
    run(4'd9, 16'h0900, 8'h00, 8'h00, 1'b1, 1'b0);
    result("R10", 16'h6080, 5, 1'b0, 16'h0902,
           '{16'h0900, 16'h0901, 16'h0902, 16'h30FF, 16'h3100}, 5);
    mem_clear(); put(16'h0A00, 8'hFE); put(16'h0A01, 8'h40);
    put(16'h40FF, 8'h22); put(16'h4100, 8'h11);
    run(4'd10, 16'h0A00, 8'h01, 8'h00, 1'b0, 1'b0);
    result("R11", 16'h1122, 5, 1'b0, 16'h0A02,
           '{16'h0A00, 16'h0A01, 16'h0A02, 16'h40FF, 16'h4100}, 5);
    @(negedge clk);
    chk("R12", "done after one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_zero_page();
    t_pre_indexed();
    t_post_indexed();
    t_absolute();
    t_zp_pointer();
    t_jumps();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R12 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule